// File: doc/BRIEF.md
# Bus Port Access Decoder

This block is the control front end of one 18-bit bidirectional port on a device that holds two FIFOs. Each clock cycle it looks at the port's active-low select, active-low enable and read/write line. It then combines a three-bit address with the transfer direction to decide which internal resource the cycle targets. The resources are the FIFO data path, an almost-empty threshold register, an almost-full threshold register and a bypass message register. Each one has its own write strobe and its own read strobe.

On an accepted cycle, the block raises a single strobe for exactly one cycle after the rising clock edge that sampled the access. On a write, it also registers the bus value so that the downstream block can capture it. For reads, the block routes the selected resource onto the port's output data. It also computes the enable for the tristate pad driver. The FIFO storage and the flag generation sit outside this block and consume the strobes.

Top module: `bus_port_ctrl`

## Requirements
- R1: While reset is held, and until the first accepted access after release, every write strobe and every read strobe is 0.
- R2: With select `sel_n` high at a rising edge, no strobe is raised in the following cycle, whatever the other inputs are.
- R3: With enable `xfer_n` high at a rising edge, no strobe is raised in the following cycle.
- R4: A write cycle (`sel_n`=0, `xfer_n`=0, `rnw`=0) to address k in 0..3 raises bit k of `wr_stb` for exactly the next cycle. In that same cycle, `wr_data` holds the bus value sampled at the edge. The slot order is 0 FIFO data, 1 almost-empty threshold, 2 almost-full threshold, 3 bypass register.
- R5: A read cycle (`rnw`=1) to address k in 0..3 raises bit k of `rd_stb` for exactly the next cycle.
- R6: An access to a reserved address (4..7) raises no strobe, in either direction.
- R7: `dq_oe` is 1 only when `oe_n`=0, `sel_n`=0 and `rnw`=1, all in the same cycle. Otherwise it is 0.
- R8: `dq_o` carries the read source chosen by the current address for 0..3, and is zero for reserved addresses.
- R9: At most one strobe bit across `wr_stb` and `rd_stb` together is high in any cycle.
- R10: Accepted accesses on back-to-back edges give strobes on back-to-back cycles, with no idle cycle inserted. A strobe never repeats without a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| sel_n | input | 1 | Active-low port select |
| xfer_n | input | 1 | Active-low transfer enable |
| rnw | input | 1 | 1 = read from device, 0 = write into device |
| oe_n | input | 1 | Active-low output enable for the data pads |
| addr | input | 3 | Resource address |
| dq_i | input | 18 | Data from the pads |
| src_fifo | input | 18 | Read source: FIFO head word |
| src_ae | input | 18 | Read source: almost-empty threshold |
| src_af | input | 18 | Read source: almost-full threshold |
| src_byp | input | 18 | Read source: bypass message |
| dq_o | output | 18 | Data to the pads |
| dq_oe | output | 1 | Pad driver enable |
| wr_stb | output | 4 | One-cycle write strobes, one per slot |
| rd_stb | output | 4 | One-cycle read strobes, one per slot |
| wr_data | output | 18 | Registered write data |

## Verification
The hardest case to reach is a stream of unbroken accepted accesses in which the address, the direction and the qualifiers change on every edge. Only that stream shows that each strobe lasts one cycle and that no neighbouring access leaks into it. The stimulus drives such a stream, including a reserved address and a deselected cycle placed between valid accesses. It also drives reads with `oe_n` toggling, so that the pad enable is checked separately from the strobe path.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int DW     = 18;
  localparam int AW     = 3;
  localparam int NSLOT  = 4;
  localparam int SLOT_W = $clog2(NSLOT);

  typedef enum logic [SLOT_W-1:0] {
    SLOT_FIFO = 2'd0,
    SLOT_AE   = 2'd1,
    SLOT_AF   = 2'd2,
    SLOT_BYP  = 2'd3
  } slot_e;
endpackage

// File: rtl/bpc_qualify.sv
module bpc_qualify
  import bpc_pkg::*;
(
  input  logic             sel_n,
  input  logic             xfer_n,
  input  logic             rnw,
  input  logic [AW-1:0]    addr,
  output logic             rsv,
  output logic [NSLOT-1:0] wr_hit,
  output logic [NSLOT-1:0] rd_hit
);
  logic acc;
  assign acc = ~sel_n & ~xfer_n;
  assign rsv = (addr >= AW'(NSLOT));

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic match;
    assign match     = (addr == AW'(k));
    assign wr_hit[k] = acc & match & ~rnw;
    assign rd_hit[k] = acc & match &  rnw;
  end
endmodule

// File: rtl/bpc_strobe.sv
module bpc_strobe
  import bpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] wr_hit,
  input  logic [NSLOT-1:0] rd_hit,
  input  logic [DW-1:0]    dq_i,
  output logic [NSLOT-1:0] wr_stb,
  output logic [NSLOT-1:0] rd_stb,
  output logic [DW-1:0]    wr_data
);
  logic [NSLOT-1:0] wr_d, rd_d;
  logic             cap_en;
  logic [DW-1:0]    data_d;

  always_comb begin
    wr_d   = wr_hit;
    rd_d   = rd_hit;
    cap_en = |wr_hit;
    data_d = cap_en ? dq_i : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= '0;
      rd_stb  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb  <= wr_d;
      rd_stb  <= rd_d;
      wr_data <= data_d;
    end
  end
endmodule

// File: rtl/bpc_rdmux.sv
module bpc_rdmux
  import bpc_pkg::*;
(
  input  logic [AW-1:0]          addr,
  input  logic                   rsv,
  input  logic [NSLOT-1:0][DW-1:0] src,
  output logic [DW-1:0]          dout
);
  always_comb begin
    if (rsv) dout = '0;
    else     dout = src[addr[SLOT_W-1:0]];
  end
endmodule

// File: rtl/bus_port_ctrl.sv
module bus_port_ctrl
  import bpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             xfer_n,
  input  logic             rnw,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dq_i,
  input  logic [DW-1:0]    src_fifo,
  input  logic [DW-1:0]    src_ae,
  input  logic [DW-1:0]    src_af,
  input  logic [DW-1:0]    src_byp,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe,
  output logic [NSLOT-1:0] wr_stb,
  output logic [NSLOT-1:0] rd_stb,
  output logic [DW-1:0]    wr_data
);
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  logic                    rsv;
  logic [NSLOT-1:0]        wr_hit, rd_hit;
  logic [NSLOT-1:0][DW-1:0] src;

  assign src[SLOT_FIFO] = src_fifo;
  assign src[SLOT_AE]   = src_ae;
  assign src[SLOT_AF]   = src_af;
  assign src[SLOT_BYP]  = src_byp;

  bpc_qualify u_qual (
    .sel_n(sel_n), .xfer_n(xfer_n), .rnw(rnw), .addr(addr),
    .rsv(rsv), .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  bpc_strobe u_stb (
    .clk(clk), .rst_n(srst_n), .wr_hit(wr_hit), .rd_hit(rd_hit),
    .dq_i(dq_i), .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_data(wr_data)
  );

  bpc_rdmux u_mux (
    .addr(addr), .rsv(rsv), .src(src), .dout(dq_o)
  );

  assign dq_oe = ~oe_n & ~sel_n & rnw;
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker
  import bpc_pkg::*;
(
  input  logic             clk,
  input  logic             srst_n,
  input  logic             sel_n,
  input  logic             xfer_n,
  input  logic             rnw,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dq_i,
  input  logic [DW-1:0]    dq_o,
  input  logic             dq_oe,
  input  logic [NSLOT-1:0] wr_stb,
  input  logic [NSLOT-1:0] rd_stb,
  input  logic [DW-1:0]    wr_data
);
  logic acc_ok;
  assign acc_ok = !sel_n && !xfer_n && (addr < AW'(NSLOT));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !srst_n |-> (wr_stb == '0 && rd_stb == '0));

  p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!srst_n)
    sel_n |=> (wr_stb == '0 && rd_stb == '0));

  p_noxfer_quiet_r3: assert property (@(posedge clk) disable iff (!srst_n)
    xfer_n |=> (wr_stb == '0 && rd_stb == '0));

  p_write_slot_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_ok && !rnw) |=> (wr_stb[$past(addr[SLOT_W-1:0])] && wr_data == $past(dq_i)));

  p_read_slot_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_ok && rnw) |=> rd_stb[$past(addr[SLOT_W-1:0])]);

  p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (!srst_n)
    addr[AW-1] |=> (wr_stb == '0 && rd_stb == '0));

  p_oe_dir_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (!rnw || sel_n) |-> !dq_oe);

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!srst_n)
    addr[AW-1] |-> (dq_o == '0));

  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({wr_stb, rd_stb}));
endmodule

bind bus_port_ctrl bpc_checker u_chk (
  .clk(clk), .srst_n(srst_n), .sel_n(sel_n), .xfer_n(xfer_n), .rnw(rnw),
  .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
  .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_data(wr_data)
);

// File: tb/sim_bus_port_ctrl.sv
`timescale 1ns/1ps
module sim_bus_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_n, xfer_n, rnw, oe_n;
  logic [2:0]  addr;
  logic [17:0] dq_i;
  logic [17:0] dq_o, wr_data;
  logic        dq_oe;
  logic [3:0]  wr_stb, rd_stb;

  localparam logic [17:0] V_FIFO = 18'h1A5A5;
  localparam logic [17:0] V_AE   = 18'h00008;
  localparam logic [17:0] V_AF   = 18'h00010;
  localparam logic [17:0] V_BYP  = 18'h2C3C3;

  always #2.5 clk = ~clk;

  bus_port_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .xfer_n(xfer_n), .rnw(rnw),
    .oe_n(oe_n), .addr(addr), .dq_i(dq_i),
    .src_fifo(V_FIFO), .src_ae(V_AE), .src_af(V_AF), .src_byp(V_BYP),
    .dq_o(dq_o), .dq_oe(dq_oe), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_data(wr_data)
  );

  typedef struct packed {
    logic [3:0]  wr;
    logic [3:0]  rd;
    logic [17:0] wd;
    logic        chk_wd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    mon_on = 1'b0;

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues what the next cycle must show.
  task automatic step(input bit s, input bit x, input bit r, input bit o,
                      input logic [2:0] a, input logic [17:0] d, input string tag);
    exp_t e;
    logic [17:0] src_exp;
    @(negedge clk);
    sel_n = s; xfer_n = x; rnw = r; oe_n = o; addr = a; dq_i = d;
    e = '0;
    if (!s && !x && a < 3'd4) begin
      if (r) e.rd[a[1:0]] = 1'b1;
      else begin
        e.wr[a[1:0]] = 1'b1;
        e.wd = d;
        e.chk_wd = 1'b1;
      end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    #1;
    check(dq_oe == (!o && !s && r), "R7",
          $sformatf("dq_oe act=%0b exp=%0b", dq_oe, (!o && !s && r)));
    case (a)
      3'd0: src_exp = V_FIFO;
      3'd1: src_exp = V_AE;
      3'd2: src_exp = V_AF;
      3'd3: src_exp = V_BYP;
      default: src_exp = '0;
    endcase
    check(dq_o == src_exp, "R8", $sformatf("dq_o act=%h exp=%h", dq_o, src_exp));
  endtask

  // Monitor: one item per cycle, sampled between edges.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_on && exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(wr_stb == e.wr && rd_stb == e.rd, t,
              $sformatf("wr/rd act=%b/%b exp=%b/%b", wr_stb, rd_stb, e.wr, e.rd));
        if (e.chk_wd)
          check(wr_data == e.wd, t, $sformatf("wr_data act=%h exp=%h", wr_data, e.wd));
        check($countones({wr_stb, rd_stb}) <= 1, "R9",
              $sformatf("strobe count act=%0d exp<=1", $countones({wr_stb, rd_stb})));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; xfer_n = 1'b1; rnw = 1'b0; oe_n = 1'b1;
    addr = '0; dq_i = '0;
    repeat (3) @(posedge clk);
    #1;
    check(wr_stb == 4'b0 && rd_stb == 4'b0, "R1",
          $sformatf("reset strobes act=%b/%b exp=0000/0000", wr_stb, rd_stb));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(wr_stb == 4'b0 && rd_stb == 4'b0, "R1",
          $sformatf("post-release strobes act=%b/%b exp=0000/0000", wr_stb, rd_stb));
    mon_on = 1'b1;

    // R4: writes to every slot, back to back (R10)
    for (int k = 0; k < 4; k++)
      step(0, 0, 0, 1, 3'(k), 18'h10000 + 18'(k * 3), "R4");
    // R5: reads to every slot, output enable toggling
    for (int k = 0; k < 4; k++)
      step(0, 0, 1, k[0], 3'(k), 18'h0, "R5");
    // R2: deselected write and read
    step(1, 0, 0, 0, 3'd1, 18'h3FFFF, "R2");
    step(1, 0, 1, 0, 3'd2, 18'h0, "R2");
    // R3: enable high
    step(0, 1, 0, 0, 3'd0, 18'h12345, "R3");
    step(0, 1, 1, 0, 3'd3, 18'h0, "R3");
    // R6: reserved addresses, both directions
    for (int k = 4; k < 8; k++) begin
      step(0, 0, 0, 0, 3'(k), 18'h2AAAA, "R6");
      step(0, 0, 1, 0, 3'(k), 18'h0, "R6");
    end
    // R10: mixed stream with gaps that must not stretch strobes
    step(0, 0, 0, 1, 3'd3, 18'h0BEEF, "R10");
    step(0, 0, 1, 0, 3'd0, 18'h0, "R10");
    step(0, 0, 0, 1, 3'd5, 18'h11111, "R10");
    step(0, 0, 0, 1, 3'd2, 18'h22222, "R10");
    step(1, 1, 1, 0, 3'd2, 18'h0, "R10");
    step(0, 0, 1, 1, 3'd1, 18'h0, "R10");
    step(1, 1, 0, 1, 3'd0, 18'h0, "R10");
    step(1, 1, 0, 1, 3'd0, 18'h0, "R10");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10",
          $sformatf("pending items act=%0d exp=0", exp_q.size()));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule